// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM. The host places one read or write request at a time on a simple request/ready handshake. The sequencer turns each request into chip-enable, write-enable and output-enable strobes, a held address, and a data bus that is either driven or released. Read results come back on `rdata` together with a one-cycle `rvalid` strobe.

Every timing minimum of the memory is a nanosecond parameter. Elaboration converts it to a cycle count by ceiling division with the clock period, and every count is at least one cycle. After reset the block holds every strobe inactive for a configurable power-stable interval before it reports ready. A write is the overlap of chip enable and write enable, which fall and rise together, so data setup is counted up to the edge that ends the write. After every read the block waits out the memory's output-release time before it accepts the next request. This keeps a following write from driving a bus the memory still drives.

The data pad is split into an output value, an output enable and an input value, so the three-state buffer sits at the chip boundary.

Top module: `sram_port_ctrl`

## Requirements
- R1: While `rst` is high, and after reset until `ready` first rises, `sramCeN`, `sramWeN` and `sramOeN` are 1, `sramDqEn` is 0, and `ready` and `rvalid` are 0.
- R2: `ready` first rises exactly PWR_CYC = ceil(T_POWERUP_NS / CLK_PERIOD_NS) clock cycles after the cycle in which `rst` is released. This is 250 cycles for 1000 ns at a 4 ns clock.
- R3: A request presented while `ready` is 0 is ignored: no strobe moves for it and the addressed memory word keeps its old value.
- R4: A read holds `sramCeN` and `sramOeN` at 0 and `sramWeN` at 1 for exactly RD_CYC consecutive cycles, with `sramAddr` stable. RD_CYC is the largest of the cycle counts of read cycle time, address-to-data, chip-enable-to-data and output-enable-to-data.
- R5: Read data is taken from `sramDqIn` at the last clock edge of the read window. `rvalid` is 1 for exactly one cycle, the first cycle after the window, and carries that word on `rdata`.
- R6: A write drops `sramCeN` and `sramWeN` at the same edge and raises them at the same edge. Both stay at 0 for exactly WR_CYC consecutive cycles with `sramOeN` at 1 and `sramAddr` stable. WR_CYC is the largest of the cycle counts of write cycle time, write pulse width, chip-enable-to-end, address-to-end and data setup.
- R7: `sramDqEn` is 1 exactly while a write window is open, and during that time `sramDqOut` equals the write data accepted with the request.
- R8: After `sramOeN` rises at the end of a read, `ready` stays 0 for exactly HZ_CYC cycles, the cycle count of the output-release time.
- R9: `ready` is 0 in every cycle in which `sramCeN` is 0. At the end of a write `ready` is already 1 in the first cycle after the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request, taken at a clock edge where `ready` is 1 |
| reqWe | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W | Request address |
| reqWData | input | DATA_W | Write data |
| ready | output | 1 | Idle and able to take a request |
| rvalid | output | 1 | One-cycle strobe marking `rdata` valid |
| rdata | output | DATA_W | Read result |
| sramCeN | output | 1 | Memory chip enable, active low |
| sramWeN | output | 1 | Memory write enable, active low |
| sramOeN | output | 1 | Memory output enable, active low |
| sramAddr | output | ADDR_W | Memory address |
| sramDqOut | output | DATA_W | Value driven onto the data pad |
| sramDqEn | output | 1 | Data pad output enable |
| sramDqIn | input | DATA_W | Value read from the data pad |

## Verification
A wrong sequencer state or counter value shows at the pins within the access it corrupts. A window that is too short or too long appears as a wrong chip-enable low count at the rising edge that closes it. A bus driven outside a write appears in the same cycle as a drive enable without both write strobes. Early capture appears when `rvalid` is raised: the bench memory model holds its output invalid until the read window has lasted long enough, and the scoreboard compares each returned word against a shadow of the host's writes. A skipped output-release wait appears as `ready` rising too soon after output enable goes high.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    ST_POWERUP,
    ST_IDLE,
    ST_READ,
    ST_RELEASE,
    ST_WRITE
  } seqState_t;

  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic dqEn;
    logic loadReq;
    logic capture;
  } strobe_t;

  // Cycle count for a minimum time, rounded up, never below one.
  function automatic int cycOf(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_port_fsm.sv
module sram_port_fsm
  import sram_port_pkg::*;
#(
  parameter int PWR_CYC = 4,
  parameter int RD_CYC  = 3,
  parameter int WR_CYC  = 3,
  parameter int HZ_CYC  = 2,
  parameter int CNT_W   = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req,
  input  logic    reqWe,
  output logic    ready,
  output strobe_t strb
);

  localparam logic [CNT_W-1:0] PWR_LOAD = CNT_W'(PWR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LOAD  = CNT_W'(HZ_CYC - 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             cntDone;

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_POWERUP;
      cnt   <= PWR_LOAD;
    end else begin
      case (state)
        ST_POWERUP: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        ST_IDLE: begin
          if (req) begin
            state <= reqWe ? ST_WRITE : ST_READ;
            cnt   <= reqWe ? WR_LOAD : RD_LOAD;
          end
        end
        ST_READ: begin
          if (cntDone) begin
            state <= ST_RELEASE;
            cnt   <= HZ_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RELEASE: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        ST_WRITE: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        default: begin
          state <= ST_POWERUP;
          cnt   <= PWR_LOAD;
        end
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.ceN     = 1'b1;
    strb.weN     = 1'b1;
    strb.oeN     = 1'b1;
    ready        = (state == ST_IDLE);
    strb.loadReq = (state == ST_IDLE) && req;
    case (state)
      ST_READ: begin
        strb.ceN     = 1'b0;
        strb.oeN     = 1'b0;
        strb.capture = cntDone;
      end
      ST_WRITE: begin
        strb.ceN  = 1'b0;
        strb.weN  = 1'b0;
        strb.dqEn = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sram_port_datapath.sv
module sram_port_datapath
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqEn
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;
  logic              rvalidReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg   <= '0;
      wdataReg  <= '0;
      rdataReg  <= '0;
      rvalidReg <= 1'b0;
    end else begin
      if (strb.loadReq) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWData;
      end
      if (strb.capture) rdataReg <= sramDqIn;
      rvalidReg <= strb.capture;
    end
  end

  assign sramCeN   = strb.ceN;
  assign sramWeN   = strb.weN;
  assign sramOeN   = strb.oeN;
  assign sramDqEn  = strb.dqEn;
  assign sramAddr  = addrReg;
  assign sramDqOut = wdataReg;
  assign rdata     = rdataReg;
  assign rvalid    = rvalidReg;

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_POWERUP_NS  = 100000,
  parameter int T_RC_NS       = 10,
  parameter int T_AA_NS       = 10,
  parameter int T_ACE_NS      = 10,
  parameter int T_DOE_NS      = 5,
  parameter int T_HZOE_NS     = 5,
  parameter int T_WC_NS       = 10,
  parameter int T_PWE_NS      = 7,
  parameter int T_SCE_NS      = 7,
  parameter int T_AW_NS       = 7,
  parameter int T_SD_NS       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              reqWe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  output logic              ready,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqEn,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int PWR_CYC = cycOf(T_POWERUP_NS, CLK_PERIOD_NS);
  localparam int RD_CYC  = maxOf(maxOf(cycOf(T_RC_NS, CLK_PERIOD_NS), cycOf(T_AA_NS, CLK_PERIOD_NS)),
                                 maxOf(cycOf(T_ACE_NS, CLK_PERIOD_NS), cycOf(T_DOE_NS, CLK_PERIOD_NS)));
  localparam int WR_CYC  = maxOf(maxOf(maxOf(cycOf(T_WC_NS, CLK_PERIOD_NS), cycOf(T_PWE_NS, CLK_PERIOD_NS)),
                                       maxOf(cycOf(T_SCE_NS, CLK_PERIOD_NS), cycOf(T_AW_NS, CLK_PERIOD_NS))),
                                 cycOf(T_SD_NS, CLK_PERIOD_NS));
  localparam int HZ_CYC  = cycOf(T_HZOE_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC = maxOf(maxOf(PWR_CYC, RD_CYC), maxOf(WR_CYC, HZ_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int MIN_WIN = (RD_CYC < WR_CYC) ? RD_CYC : WR_CYC;

  strobe_t strb;

  sram_port_fsm #(
    .PWR_CYC(PWR_CYC),
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .HZ_CYC (HZ_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .reqWe(reqWe),
    .ready(ready),
    .strb (strb)
  );

  sram_port_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWData (reqWData),
    .sramDqIn (sramDqIn),
    .rvalid   (rvalid),
    .rdata    (rdata),
    .sramCeN  (sramCeN),
    .sramWeN  (sramWeN),
    .sramOeN  (sramOeN),
    .sramAddr (sramAddr),
    .sramDqOut(sramDqOut),
    .sramDqEn (sramDqEn)
  );

endmodule

// File: rtl/sram_port_checker.sv
module sram_port_checker #(
  parameter int MIN_LOW = 1
) (
  input logic clk,
  input logic rst,
  input logic ready,
  input logic rvalid,
  input logic sramCeN,
  input logic sramWeN,
  input logic sramOeN,
  input logic sramDqEn
);

  logic [15:0] lowLen;

  always_ff @(posedge clk) begin
    if (rst)           lowLen <= '0;
    else if (sramCeN)  lowLen <= '0;
    else if (lowLen != 16'hFFFF) lowLen <= lowLen + 16'd1;
  end

  // R7: the pad is driven only inside a write window
  assert_drive_only_writing_R7: assert property (@(posedge clk) disable iff (rst)
    sramDqEn |-> (!sramCeN && !sramWeN && sramOeN));

  // R6: write enable falls together with chip enable
  assert_we_falls_with_ce_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sramWeN) |-> $fell(sramCeN));

  // R6: write enable rises together with chip enable
  assert_we_rises_with_ce_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sramWeN) |-> $rose(sramCeN));

  // R4: output enable never overlaps write enable
  assert_oe_excludes_we_R4: assert property (@(posedge clk) disable iff (rst)
    !sramOeN |-> sramWeN);

  // R5: rvalid is a single-cycle pulse
  assert_rvalid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

  // R9: busy while the memory is selected
  assert_busy_while_selected_R9: assert property (@(posedge clk) disable iff (rst)
    !sramCeN |-> !ready);

  // R8: output release wait follows every read
  assert_release_wait_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sramOeN) |-> !ready);

  // R4: no access window is shorter than the shorter of the two minima
  assert_window_floor_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sramCeN) |-> (lowLen >= 16'(MIN_LOW)));

endmodule

bind sram_port_ctrl sram_port_checker #(.MIN_LOW(MIN_WIN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ready   (ready),
  .rvalid  (rvalid),
  .sramCeN (sramCeN),
  .sramWeN (sramWeN),
  .sramOeN (sramOeN),
  .sramDqEn(sramDqEn)
);

// File: tb/sram_port_ctrl_test.sv
module sram_port_ctrl_test;

  localparam int AW      = 18;
  localparam int DW      = 16;
  localparam int PWR_CYC = 250;   // ceil(1000 / 4)
  localparam int RD_CYC  = 3;     // ceil(10 / 4)
  localparam int WR_CYC  = 3;     // ceil(10 / 4)
  localparam int HZ_CYC  = 2;     // ceil(5 / 4)

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          reqWe = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWData = '0;
  logic          ready, rvalid;
  logic [DW-1:0] rdata;
  logic          sramCeN, sramWeN, sramOeN, sramDqEn;
  logic [AW-1:0] sramAddr;
  logic [DW-1:0] sramDqOut;
  logic [DW-1:0] sramDqIn = 16'hBAD0;

  always #2 clk = ~clk;

  sram_port_ctrl #(.T_POWERUP_NS(1000)) uut (
    .clk(clk), .rst(rst), .req(req), .reqWe(reqWe), .reqAddr(reqAddr),
    .reqWData(reqWData), .ready(ready), .rvalid(rvalid), .rdata(rdata),
    .sramCeN(sramCeN), .sramWeN(sramWeN), .sramOeN(sramOeN),
    .sramAddr(sramAddr), .sramDqOut(sramDqOut), .sramDqEn(sramDqEn),
    .sramDqIn(sramDqIn)
  );

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] expMem [256];
  logic [DW-1:0] expQ [$];
  logic [DW-1:0] curWData = '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Driver: waits for ready, presents one request, pushes the expected result.
  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit holdStale);
    while (!ready) @(negedge clk);
    req = 1'b1; reqWe = w; reqAddr = a; reqWData = d;
    if (w) begin
      expMem[a[7:0]] = d;
      curWData = d;
    end else begin
      expQ.push_back(expMem[a[7:0]]);
    end
    @(negedge clk);
    if (holdStale) begin
      // R3: request held while busy must be ignored
      reqWe = 1'b1; reqAddr = 18'h00055; reqWData = 16'hBEEF;
      @(negedge clk);
    end
    req = 1'b0;
  endtask

  // Monitor and memory model, sampled away from the active edge.
  bit          everReady = 1'b0;
  int          ceLow = 0;
  bit          winWrite = 1'b0;
  logic [AW-1:0] winAddr = '0;
  logic [DW-1:0] lastD = '0;
  logic        prevOeN = 1'b1;
  int          readLow = 0;
  bit          relCounting = 1'b0;
  int          relLow = 0;

  always @(negedge clk) begin
    if (rst || !everReady) begin
      chk(sramCeN && sramWeN && sramOeN && !sramDqEn, "R1", "strobes idle",
          {sramCeN, sramWeN, sramOeN, sramDqEn}, 4'b1110);
      chk(!rvalid, "R1", "rvalid low", rvalid, 0);
    end
    if (rst) chk(!ready, "R1", "ready low in reset", ready, 0);
    if (!rst) begin
      if (ready) everReady = 1'b1;
      if (!sramCeN) begin
        if (ceLow == 0) begin
          winWrite = !sramWeN;
          winAddr  = sramAddr;
        end
        ceLow++;
        chk(sramAddr == winAddr, winWrite ? "R6" : "R4", "address stable", sramAddr, winAddr);
        chk(!ready, "R9", "ready low while selected", ready, 0);
        if (winWrite) begin
          chk(!sramWeN && sramOeN, "R6", "write strobes", {sramWeN, sramOeN}, 2'b01);
          lastD = sramDqOut;
        end else begin
          chk(sramWeN && !sramOeN, "R4", "read strobes", {sramWeN, sramOeN}, 2'b10);
        end
      end else if (ceLow != 0) begin
        chk(ceLow == (winWrite ? WR_CYC : RD_CYC), winWrite ? "R6" : "R4", "window length",
            ceLow, winWrite ? WR_CYC : RD_CYC);
        if (winWrite) begin
          mem[winAddr[7:0]] = lastD;
          chk(ready, "R9", "ready after write", ready, 1);
        end
        ceLow = 0;
      end
      chk(sramDqEn == (!sramCeN && !sramWeN), "R7", "drive enable", sramDqEn, !sramCeN && !sramWeN);
      if (sramDqEn) chk(sramDqOut == curWData, "R7", "driven data", sramDqOut, curWData);
      chk(rvalid == (sramOeN && !prevOeN), "R5", "rvalid timing", rvalid, sramOeN && !prevOeN);
      if (rvalid) begin
        if (expQ.size() == 0) chk(1'b0, "R5", "unexpected rvalid", rdata, 0);
        else begin
          logic [DW-1:0] e;
          e = expQ.pop_front();
          chk(rdata == e, "R5", "read data", rdata, e);
        end
      end
      if (sramOeN && !prevOeN) begin
        relCounting = 1'b1;
        relLow = 0;
      end
      if (relCounting) begin
        if (!ready) relLow++;
        else begin
          chk(relLow == HZ_CYC, "R8", "release wait", relLow, HZ_CYC);
          relCounting = 1'b0;
        end
      end
      if (!sramCeN && !sramOeN) readLow++;
      else readLow = 0;
      sramDqIn = (readLow >= RD_CYC) ? mem[sramAddr[7:0]] : 16'hBAD0;
    end
    prevOeN = sramOeN;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 16'(i * 7 + 16'h3000);
      expMem[i] = 16'(i * 7 + 16'h3000);
    end
    // R3: a write request is held during reset and power-up
    req = 1'b1; reqWe = 1'b1; reqAddr = 18'h00055; reqWData = 16'hBEEF;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    begin
      int n;
      n = 0;
      while (!ready && n < 1000) begin
        @(negedge clk);
        n++;
        if (n == 20) req = 1'b0;
      end
      chk(n == PWR_CYC, "R2", "power-up wait", n, PWR_CYC);
    end
    issue(1'b1, 18'h00001, 16'hA5A5, 1'b0);
    issue(1'b1, 18'h00002, 16'h5A5A, 1'b0);
    issue(1'b0, 18'h00001, '0, 1'b0);
    issue(1'b0, 18'h00002, '0, 1'b0);
    issue(1'b0, 18'h00055, '0, 1'b0);          // R3: untouched by stale request
    issue(1'b1, 18'h00003, 16'h0000, 1'b0);    // write right after read: R8
    issue(1'b1, 18'h00004, 16'hFFFF, 1'b1);    // stale request held while busy: R3
    issue(1'b0, 18'h00055, '0, 1'b0);
    issue(1'b0, 18'h00004, '0, 1'b0);
    issue(1'b0, 18'h00003, '0, 1'b0);
    issue(1'b1, 18'h3FF80, 16'h1234, 1'b0);
    issue(1'b0, 18'h3FF80, '0, 1'b0);
    issue(1'b0, 18'h00009, '0, 1'b0);
    begin
      int w;
      w = 0;
      while (expQ.size() != 0 && w < 100) begin
        @(negedge clk);
        w++;
      end
    end
    repeat (5) @(negedge clk);
    chk(expQ.size() == 0, "R5", "all reads returned", expQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule